// File: doc/BRIEF.md
# System Exception Control Register Block

This block is the software-facing register page for a handful of fixed system exceptions: non-maskable, deferred service call, system tick, memory fault, bus fault, usage fault, supervisor call and debug. A processor reaches it through a simple request port carrying a 12-bit byte offset, an access size and write data. Writes raise one-cycle pending-set and pending-clear strobes toward the exception logic, load the vector table base, the fault enables and the handler priority bytes, issue a keyed system reset request and trigger external interrupts by number.

Reads report live status that the surrounding controller drives in: the active vector, the highest pending vector, per-exception active and pending flags, and two summary flags for the external interrupts. Prioritisation and arbitration live elsewhere; this block only formats status and produces commands.

A read request is answered on `rd_data` in the cycle after it is accepted, and `rd_data` then holds until the next read.

Top module: `sysexc_regs`

## Requirements
- R1: After reset `rd_data`, `vtor`, `fault_en`, `prio_bytes`, `pend_set`, `pend_clr`, `reset_req` and `trig_valid` are all zero.
- R2: A word write to offset 0xD04 produces, in the cycle after the write, a one-cycle strobe: bit 31 raises `pend_set[0]` (non-maskable), bit 28 raises `pend_set[1]` (deferred service), bit 27 raises `pend_clr[1]`, bit 26 raises `pend_set[2]` (system tick), bit 25 raises `pend_clr[2]`; `pend_clr[0]` never rises.
- R3: When both the set bit and the clear bit of one exception are written as 1, only the set strobe fires.
- R4: A word read of 0xD04 returns the active vector in bits [8:0], the highest pending vector in bits [20:12] (either vector equal to 1023 reads as 0), `ext_pend_any` at bit 22, `other_active` at bit 11, and the pending flags of non-maskable, deferred service and tick at bits 31, 28 and 26.
- R5: A word write to 0xD08 loads `vtor` with the data masked by 0xFFFFFF80; a word read of 0xD08 returns that value; `vtor` changes on no other access.
- R6: A word write to 0xD0C with bits [31:16] equal to 0x05FA and bit 2 set pulses `reset_req` for one cycle; any other key gives no pulse; a word read of 0xD0C returns 0xFA050000.
- R7: A word read of 0xD24 reports active flags of memory fault, bus fault, usage fault, supervisor call, debug, deferred service and tick at bits 0, 1, 3, 7, 8, 10, 11, pending flags of usage, memory, bus fault and supervisor call at bits 12, 13, 14, 15, and `fault_en[0..2]` (memory, bus, usage) at bits 16, 17, 18; a word write changes only `fault_en`, from data bits 18:16. `sys_active`/`sys_pending` index: 0 non-maskable, 1 deferred service, 2 tick, 3 memory, 4 bus, 5 usage, 6 supervisor call, 7 debug.
- R8: Twelve handler priority bytes at offsets 0xD18 to 0xD23 accept byte, halfword and word accesses (size 0, 1, 2); access lane i maps to byte offset+i, lanes past 0xD23 are dropped; byte k appears at `prio_bytes[8k+7:8k]`.
- R9: A word write to 0xF00 pulses `trig_valid` with `trig_num` equal to data bits [8:0] only when that number is below NUM_IRQ.
- R10: A word read of offset 0x004 returns NUM_IRQ/32 - 1.
- R11: Unmapped offsets read as zero and writes to them change nothing; non-word accesses to the word registers read zero and are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 12 | Byte offset within the page |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 invalid |
| req_wdata | input | 32 | Write data, lane 0 in bits 7:0 |
| rd_data | output | 32 | Read data, valid the cycle after a read |
| act_vec | input | 10 | Currently active vector, 1023 for none |
| pend_vec | input | 10 | Highest pending vector, 1023 for none |
| ext_pend_any | input | 1 | Some external interrupt is pending |
| other_active | input | 1 | Some interrupt besides the current one is active |
| sys_active | input | 8 | Active flags of the system exceptions |
| sys_pending | input | 8 | Pending flags of the system exceptions |
| pend_set | output | 3 | Pending-set strobes: non-maskable, deferred, tick |
| pend_clr | output | 3 | Pending-clear strobes, same order |
| fault_en | output | 3 | Memory, bus, usage fault enables |
| vtor | output | 32 | Vector table base |
| prio_bytes | output | 96 | Handler priority bytes |
| reset_req | output | 1 | System reset request pulse |
| trig_valid | output | 1 | Software interrupt trigger strobe |
| trig_num | output | 9 | Triggered interrupt number |

## Verification
The bench builds the block with NUM_IRQ set to 96 rather than the default 64, so the type register reads 2 and the trigger bound can be probed on both sides at 95 and 96 as well as with a number that only fits after masking to nine bits. The priority bytes keep their fixed count of twelve, which puts a halfword access at the last two bytes of the range within reach.

// File: rtl/sysexc_pkg.sv
package sysexc_pkg;
    localparam int E_NMI  = 0;
    localparam int E_DSV  = 1;
    localparam int E_TICK = 2;
    localparam int E_MEM  = 3;
    localparam int E_BUS  = 4;
    localparam int E_USG  = 5;
    localparam int E_SVC  = 6;
    localparam int E_DBG  = 7;
    localparam int NUM_SYS = 8;

    localparam logic [11:0] A_TYPE   = 12'h004;
    localparam logic [11:0] A_ICSR   = 12'hD04;
    localparam logic [11:0] A_VTOR   = 12'hD08;
    localparam logic [11:0] A_AIRCR  = 12'hD0C;
    localparam logic [11:0] A_PRIO   = 12'hD18;
    localparam logic [11:0] A_SHCSR  = 12'hD24;
    localparam logic [11:0] A_STIR   = 12'hF00;

    localparam logic [15:0] RST_KEY   = 16'h05FA;
    localparam logic [31:0] AIRCR_RD  = 32'hFA050000;
    localparam logic [31:0] VTOR_MASK = 32'hFFFFFF80;
    localparam logic [9:0]  VEC_NONE  = 10'd1023;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;
endpackage

// File: rtl/sysexc_status_fmt.sv
module sysexc_status_fmt
    import sysexc_pkg::*;
#(
    parameter int VEC_W = 10
) (
    input  logic [VEC_W-1:0]   act_vec,
    input  logic [VEC_W-1:0]   pend_vec,
    input  logic               ext_pend_any,
    input  logic               other_active,
    input  logic [NUM_SYS-1:0] sys_active,
    input  logic [NUM_SYS-1:0] sys_pending,
    input  logic [2:0]         fault_en,
    output logic [31:0]        ctl_word,
    output logic [31:0]        hnd_word
);
    logic unused_flags;
    assign unused_flags = sys_pending[E_DBG] ^ sys_active[E_NMI];

    always_comb begin
        ctl_word = '0;
        if (act_vec != VEC_NONE)  ctl_word[8:0]   = act_vec[8:0];
        if (pend_vec != VEC_NONE) ctl_word[20:12] = pend_vec[8:0];
        ctl_word[22] = ext_pend_any;
        ctl_word[11] = other_active;
        ctl_word[31] = sys_pending[E_NMI];
        ctl_word[28] = sys_pending[E_DSV];
        ctl_word[26] = sys_pending[E_TICK];
    end

    always_comb begin
        hnd_word = '0;
        hnd_word[0]  = sys_active[E_MEM];
        hnd_word[1]  = sys_active[E_BUS];
        hnd_word[3]  = sys_active[E_USG];
        hnd_word[7]  = sys_active[E_SVC];
        hnd_word[8]  = sys_active[E_DBG];
        hnd_word[10] = sys_active[E_DSV];
        hnd_word[11] = sys_active[E_TICK];
        hnd_word[12] = sys_pending[E_USG];
        hnd_word[13] = sys_pending[E_MEM];
        hnd_word[14] = sys_pending[E_BUS];
        hnd_word[15] = sys_pending[E_SVC];
        hnd_word[18:16] = fault_en;
    end
endmodule

// File: rtl/sysexc_prio_bank.sv
module sysexc_prio_bank #(
    parameter int N_BYTES = 12,
    localparam int IDX_W  = $clog2(N_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   off,
    input  logic [2:0]         nbytes,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    output logic [N_BYTES*8-1:0] bytes_flat
);
    logic [7:0] bytes_q [N_BYTES];
    logic [7:0] bytes_d [N_BYTES];

    always_comb begin
        for (int j = 0; j < N_BYTES; j++) begin
            int rel;
            rel = j - int'(off);
            bytes_d[j] = bytes_q[j];
            if (wr_en && rel >= 0 && rel < int'(nbytes))
                bytes_d[j] = wdata[8*rel +: 8];
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < 4; i++) begin
            int k;
            k = int'(off) + i;
            if (i < int'(nbytes) && k < N_BYTES)
                rdata[8*i +: 8] = bytes_q[k[IDX_W-1:0]];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int j = 0; j < N_BYTES; j++) bytes_q[j] <= '0;
        end else begin
            for (int j = 0; j < N_BYTES; j++) bytes_q[j] <= bytes_d[j];
        end
    end

    for (genvar g = 0; g < N_BYTES; g++) begin : g_flat
        assign bytes_flat[8*g +: 8] = bytes_q[g];
    end

    // R8: priority bytes move only after a write into the range
    p_prio_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(bytes_flat))
        else $error("priority bytes changed without a write");
endmodule

// File: rtl/sysexc_regs.sv
module sysexc_regs
    import sysexc_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int VEC_W   = 10,
    parameter int TRIG_W  = 9,
    parameter int PRIO_N  = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [11:0]          req_addr,
    input  logic [1:0]           req_size,
    input  logic [31:0]          req_wdata,
    output logic [31:0]          rd_data,
    input  logic [VEC_W-1:0]     act_vec,
    input  logic [VEC_W-1:0]     pend_vec,
    input  logic                 ext_pend_any,
    input  logic                 other_active,
    input  logic [NUM_SYS-1:0]   sys_active,
    input  logic [NUM_SYS-1:0]   sys_pending,
    output logic [2:0]           pend_set,
    output logic [2:0]           pend_clr,
    output logic [2:0]           fault_en,
    output logic [31:0]          vtor,
    output logic [PRIO_N*8-1:0]  prio_bytes,
    output logic                 reset_req,
    output logic                 trig_valid,
    output logic [TRIG_W-1:0]    trig_num
);
    localparam int IDX_W = $clog2(PRIO_N);
    localparam logic [31:0] TYPE_VAL = 32'(NUM_IRQ / 32 - 1);
    localparam logic [11:0] A_PRIO_HI = A_PRIO + 12'(PRIO_N - 1);

    typedef struct packed {
        logic [31:0]       vtor;
        logic [2:0]        fault_en;
        logic [31:0]       rdata;
        logic [2:0]        set;
        logic [2:0]        clr;
        logic              rst_req;
        logic              trig;
        logic [TRIG_W-1:0] trig_num;
    } regs_t;

    regs_t r_q, r_d;

    acc_size_e  sz;
    logic       wr, rd, word_acc, prio_hit;
    logic [2:0] nbytes;
    logic [IDX_W-1:0] prio_off;
    logic [31:0] prio_rd, ctl_word, hnd_word;
    logic [11:0] prio_rel;

    assign sz       = acc_size_e'(req_size);
    assign wr       = req_valid && req_write;
    assign rd       = req_valid && !req_write;
    assign word_acc = (sz == SZ_WORD);
    assign nbytes   = (sz == SZ_BYTE) ? 3'd1 : (sz == SZ_HALF) ? 3'd2 : 3'd4;
    assign prio_hit = (sz != SZ_BAD) && req_addr >= A_PRIO && req_addr <= A_PRIO_HI;
    assign prio_rel = req_addr - A_PRIO;
    assign prio_off = prio_rel[IDX_W-1:0];

    sysexc_prio_bank #(.N_BYTES(PRIO_N)) u_prio (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr && prio_hit),
        .off        (prio_off),
        .nbytes     (nbytes),
        .wdata      (req_wdata),
        .rdata      (prio_rd),
        .bytes_flat (prio_bytes)
    );

    sysexc_status_fmt #(.VEC_W(VEC_W)) u_fmt (
        .act_vec      (act_vec),
        .pend_vec     (pend_vec),
        .ext_pend_any (ext_pend_any),
        .other_active (other_active),
        .sys_active   (sys_active),
        .sys_pending  (sys_pending),
        .fault_en     (r_q.fault_en),
        .ctl_word     (ctl_word),
        .hnd_word     (hnd_word)
    );

    always_comb begin
        r_d          = r_q;
        r_d.set      = '0;
        r_d.clr      = '0;
        r_d.rst_req  = 1'b0;
        r_d.trig     = 1'b0;

        if (wr && word_acc) begin
            unique case (req_addr)
                A_ICSR: begin
                    r_d.set[E_NMI]  = req_wdata[31];
                    r_d.set[E_DSV]  = req_wdata[28];
                    r_d.clr[E_DSV]  = req_wdata[27] && !req_wdata[28];
                    r_d.set[E_TICK] = req_wdata[26];
                    r_d.clr[E_TICK] = req_wdata[25] && !req_wdata[26];
                end
                A_VTOR:  r_d.vtor = req_wdata & VTOR_MASK;
                A_AIRCR: r_d.rst_req = (req_wdata[31:16] == RST_KEY) && req_wdata[2];
                A_SHCSR: r_d.fault_en = req_wdata[18:16];
                A_STIR: begin
                    if (32'(req_wdata[TRIG_W-1:0]) < 32'(NUM_IRQ)) begin
                        r_d.trig     = 1'b1;
                        r_d.trig_num = req_wdata[TRIG_W-1:0];
                    end
                end
                default: ;
            endcase
        end

        if (rd) begin
            r_d.rdata = '0;
            if (prio_hit) begin
                r_d.rdata = prio_rd;
            end else if (word_acc) begin
                unique case (req_addr)
                    A_TYPE:  r_d.rdata = TYPE_VAL;
                    A_ICSR:  r_d.rdata = ctl_word;
                    A_VTOR:  r_d.rdata = r_q.vtor;
                    A_AIRCR: r_d.rdata = AIRCR_RD;
                    A_SHCSR: r_d.rdata = hnd_word;
                    default: r_d.rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_data    = r_q.rdata;
    assign vtor       = r_q.vtor;
    assign fault_en   = r_q.fault_en;
    assign pend_set   = r_q.set;
    assign pend_clr   = r_q.clr;
    assign reset_req  = r_q.rst_req;
    assign trig_valid = r_q.trig;
    assign trig_num   = r_q.trig_num;

    // R3: a set and a clear for the same exception never leave together
    p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_set & pend_clr) == 3'b000)
        else $error("set and clear strobes overlap");

    // R2: the non-maskable exception has no clear strobe
    p_no_nmi_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_clr[E_NMI])
        else $error("clear strobe for non-maskable exception");

    // R5: vector base keeps its low seven bits clear and moves only on writes
    p_vtor_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vtor[6:0] == 7'd0)
        else $error("vector base low bits set");
    p_vtor_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr) |-> $stable(vtor))
        else $error("vector base changed without a write");

    // R6: reset request only follows a write
    p_rst_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(wr))
        else $error("reset request without a write");

    // R7: fault enables move only after a write
    p_fault_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr) |-> $stable(fault_en))
        else $error("fault enables changed without a write");

    // R9: a trigger never carries an out-of-range number
    p_trig_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trig_valid |-> (32'(trig_num) < 32'(NUM_IRQ)))
        else $error("trigger number out of range");
endmodule

// File: tb/sysexc_regs_test.sv
module sysexc_regs_test;
    localparam int NIRQ = 96;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic [9:0]  act_vec = 10'd1023, pend_vec = 10'd1023;
    logic        ext_pend_any = 1'b0, other_active = 1'b0;
    logic [7:0]  sys_active = '0, sys_pending = '0;
    logic [2:0]  pend_set, pend_clr, fault_en;
    logic [31:0] vtor;
    logic [95:0] prio_bytes;
    logic        reset_req, trig_valid;
    logic [8:0]  trig_num;

    int checks = 0;
    int failures = 0;

    logic [2:0] s_set, s_clr;
    logic       s_rst, s_trig;
    logic [8:0] s_num;
    logic [31:0] rv;

    always #2 clk = ~clk;

    sysexc_regs #(.NUM_IRQ(NIRQ)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rd_data(rd_data), .act_vec(act_vec), .pend_vec(pend_vec),
        .ext_pend_any(ext_pend_any), .other_active(other_active),
        .sys_active(sys_active), .sys_pending(sys_pending),
        .pend_set(pend_set), .pend_clr(pend_clr), .fault_en(fault_en),
        .vtor(vtor), .prio_bytes(prio_bytes), .reset_req(reset_req),
        .trig_valid(trig_valid), .trig_num(trig_num)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = sz; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        s_set = pend_set; s_clr = pend_clr; s_rst = reset_req;
        s_trig = trig_valid; s_num = trig_num;
    endtask

    task automatic do_read(input logic [11:0] a, input logic [1:0] sz, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
        @(negedge clk);
        req_valid = 1'b0;
        d = rd_data;
    endtask

    task automatic t_reset();
        check("R1 rd_data", rd_data, 0);
        check("R1 vtor", vtor, 0);
        check("R1 fault_en", 32'(fault_en), 0);
        check("R1 prio", 32'(|prio_bytes), 0);
        check("R1 strobes", 32'({pend_set, pend_clr, reset_req, trig_valid}), 0);
    endtask

    task automatic t_icsr_write();
        do_write(12'hD04, 2, 32'h8000_0000);
        check("R2 nmi set", 32'({s_set, s_clr}), 32'b001_000);
        do_write(12'hD04, 2, 32'h1200_0000);
        check("R2 dsv set tick clr", 32'({s_set, s_clr}), 32'b010_100);
        do_write(12'hD04, 2, 32'h0C00_0000);
        check("R2 tick set dsv clr", 32'({s_set, s_clr}), 32'b100_010);
        @(negedge clk);
        check("R2 one cycle", 32'({pend_set, pend_clr}), 0);
    endtask

    task automatic t_set_wins();
        do_write(12'hD04, 2, 32'h1E00_0000);
        check("R3 set wins", 32'({s_set, s_clr}), 32'b110_000);
    endtask

    task automatic t_icsr_read();
        act_vec = 10'd37; pend_vec = 10'd45; ext_pend_any = 1; other_active = 1;
        sys_pending = 8'b0000_0101;
        do_read(12'hD04, 2, rv);
        check("R4 status", rv, 32'd37 | (32'd45 << 12) | (32'd1 << 22) | (32'd1 << 11)
                               | (32'd1 << 31) | (32'd1 << 26));
        act_vec = 10'd1023; pend_vec = 10'd1023; ext_pend_any = 0; other_active = 0;
        sys_pending = 8'b0000_0010;
        do_read(12'hD04, 2, rv);
        check("R4 none", rv, 32'd1 << 28);
        sys_pending = '0;
    endtask

    task automatic t_vtor();
        do_write(12'hD08, 2, 32'h2000_01FF);
        check("R5 vtor out", vtor, 32'h2000_0180);
        do_read(12'hD08, 2, rv);
        check("R5 vtor read", rv, 32'h2000_0180);
    endtask

    task automatic t_aircr();
        do_write(12'hD0C, 2, 32'h05FA_0004);
        check("R6 keyed pulse", 32'(s_rst), 1);
        @(negedge clk);
        check("R6 pulse ends", 32'(reset_req), 0);
        do_write(12'hD0C, 2, 32'h05FB_0004);
        check("R6 bad key", 32'(s_rst), 0);
        do_read(12'hD0C, 2, rv);
        check("R6 read", rv, 32'hFA05_0000);
    endtask

    task automatic t_shcsr();
        sys_active = 8'b0000_1000;
        do_read(12'hD24, 2, rv);
        check("R7 mem active", rv, 32'h1);
        sys_active = 8'b0000_0010;
        do_read(12'hD24, 2, rv);
        check("R7 dsv active", rv, 32'h400);
        sys_active = 8'hFF; sys_pending = 8'hFF;
        do_write(12'hD24, 2, 32'hFFFF_FFFF);
        check("R7 enables", 32'(fault_en), 7);
        do_read(12'hD24, 2, rv);
        check("R7 full", rv, 32'h0007_FD8B);
        do_write(12'hD24, 2, 32'h0002_0000);
        check("R7 bus only", 32'(fault_en), 2);
        sys_active = '0; sys_pending = '0;
    endtask

    task automatic t_prio();
        do_write(12'hD18, 2, 32'h4433_2211);
        do_write(12'hD1D, 0, 32'h0000_00AB);
        do_write(12'hD22, 1, 32'h0000_BEEF);
        check("R8 out low", prio_bytes[31:0], 32'h4433_2211);
        check("R8 out byte5", 32'(prio_bytes[47:40]), 32'hAB);
        check("R8 out top", 32'(prio_bytes[95:80]), 32'hBEEF);
        do_read(12'hD18, 2, rv);
        check("R8 word read", rv, 32'h4433_2211);
        do_read(12'hD22, 1, rv);
        check("R8 half read", rv, 32'h0000_BEEF);
        do_read(12'hD1D, 0, rv);
        check("R8 byte read", rv, 32'h0000_00AB);
        do_read(12'hD23, 2, rv);
        check("R8 past end", rv, 32'h0000_00BE);
    endtask

    task automatic t_stir();
        do_write(12'hF00, 2, 32'd95);
        check("R9 in range", 32'({s_trig, s_num}), 32'({1'b1, 9'd95}));
        do_write(12'hF00, 2, 32'd96);
        check("R9 out of range", 32'(s_trig), 0);
        do_write(12'hF00, 2, 32'h0000_0205);
        check("R9 masked", 32'({s_trig, s_num}), 32'({1'b1, 9'd5}));
    endtask

    task automatic t_type();
        do_read(12'h004, 2, rv);
        check("R10 type", rv, 32'd2);
    endtask

    task automatic t_unmapped();
        do_read(12'hD10, 2, rv);
        check("R11 unmapped read", rv, 0);
        do_write(12'hD10, 2, 32'hFFFF_FFFF);
        check("R11 unmapped write", 32'({s_set, s_clr, s_rst, s_trig}), 0);
        check("R11 vtor kept", vtor, 32'h2000_0180);
        do_write(12'hD08, 0, 32'h0000_FF00);
        check("R11 byte to vtor", vtor, 32'h2000_0180);
        do_read(12'hD0C, 1, rv);
        check("R11 half read", rv, 0);
        check("R11 enables kept", 32'(fault_en), 2);
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_icsr_write();
        t_set_wins();
        t_icsr_read();
        t_vtor();
        t_aircr();
        t_shcsr();
        t_prio();
        t_stir();
        t_type();
        t_unmapped();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule